// File: doc/BRIEF.md
# Device Cache Snoop Responder

This block keeps MESI coherence state for a small direct-mapped cache on the device side of a coherent link. The host sends snoops on its request channel. For each snoop the block looks up the addressed 64-byte line, applies the state change that the snoop kind calls for, and returns a two-bit response code. When the line held dirty data, the block then streams the whole line back as two 256-bit beats. A device-side local port installs lines with a chosen state (fill) and overwrites lines that the device already owns (write-hit).

The host response channel also passes through the block. A response is never allowed to overtake a snoop to the same line that arrived before it. Host responses go into a small in-order queue. The head of the queue waits while a snoop to its line is either waiting at the snoop input or still streaming its data. Neither the response path nor the data path back-pressures the host.

Top module: `dc_snoop_responder`

## Requirements
- R1: After reset every line is Invalid, `snp_ready` and `loc_ready` are high, and `rsp_valid`, `dat_valid`, `hout_valid` and `loc_err` are low.
- R2: A fill writes the tag, the data and the state from `loc_fill_st`, encoded as I=00, S=01, E=10, M=11. The set is `loc_line[3:0]` (address bits 9:6) and the tag is the remaining upper line-address bits.
- R3: An invalidate snoop (`snp_type`=00) that hits leaves the line Invalid. It answers 11 with data if the line was M, and 00 if the line was E or S.
- R4: A data snoop (`snp_type`=01) that hits leaves the line Shared. It answers 11 with data if the line was M, and 01 if the line was E or S.
- R5: A current snoop (`snp_type`=10, and 11 is treated the same way) never changes the state. It answers 11 with data if the line was M, and 10 if the line was E or S.
- R6: A snoop whose tag does not match, or whose line is Invalid, answers 00. It sends no data and changes no state.
- R7: `rsp_valid` is a one-cycle pulse in the cycle after the snoop handshake, with `rsp_addr` equal to the snoop address. On code 11, data bits 255:0 appear in the next cycle and bits 511:256 in the cycle after that. `snp_ready` is low from the response until the last beat. After any other code `snp_ready` stays high.
- R8: A local write (`loc_op`=1) to a line held in E or M replaces the data and leaves the line M. A local write to a line held in S, or to a line that misses, changes nothing and raises `loc_err` for one cycle after the handshake.
- R9: A host response normally leaves on `hout_*` two cycles after it is presented, in arrival order. While a snoop to the same line is waiting at the snoop input or still sending beats, the response is held until that snoop's last beat has been issued.
- R10: `loc_ready` is low while a snoop is valid at the input or data beats are pending, so that snoops take priority over local updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snp_valid | input | 1 | Snoop request valid |
| snp_ready | output | 1 | Snoop can be accepted |
| snp_addr | input | AW | Snoop byte address |
| snp_type | input | 2 | 00 invalidate, 01 data, 10/11 current |
| rsp_valid | output | 1 | Snoop response pulse |
| rsp_code | output | 2 | 00 none, 01 now shared, 10 unchanged, 11 data follows |
| rsp_addr | output | AW | Address of the answered snoop |
| dat_valid | output | 1 | Data beat valid |
| dat_beat | output | BEAT_W | Line data beat, low half first |
| hin_valid | input | 1 | Host response in |
| hin_addr | input | AW | Host response address |
| hin_code | input | HCW | Host response payload (opaque) |
| hout_valid | output | 1 | Ordered host response out |
| hout_addr | output | AW | Ordered response address |
| hout_code | output | HCW | Ordered response payload |
| loc_valid | input | 1 | Local update valid |
| loc_ready | output | 1 | Local update can be accepted |
| loc_op | input | 1 | 0 fill, 1 write-hit |
| loc_line | input | AW-6 | Line address of the local update |
| loc_fill_st | input | 2 | State installed by a fill |
| loc_data | input | LINE_W | Line data written |
| loc_err | output | 1 | Local write rejected |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 16 sets, 512-bit lines split into two 256-bit beats, and a four-entry host response queue. With these values, two addresses that differ only above bit 9 fall in the same set. This exposes tag-mismatch misses next to real hits. The two-beat split lets the bench compare each half of every returned line against a pattern computed from a seed. The bench drives a host response to the line being snooped during a dirty snoop, and another to a different line. This shows both the held path and the two-cycle pass-through path.

// File: rtl/dcsr_pkg.sv
package dcsr_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } mesi_e;

  localparam logic [1:0] SNP_INV  = 2'b00;
  localparam logic [1:0] SNP_DATA = 2'b01;

  localparam logic [1:0] RSP_NONE   = 2'b00;
  localparam logic [1:0] RSP_SHARED = 2'b01;
  localparam logic [1:0] RSP_KEEP   = 2'b10;
  localparam logic [1:0] RSP_DATA   = 2'b11;

  // state reached after a snoop hit
  function automatic mesi_e snoop_next(mesi_e cur, logic [1:0] kind);
    mesi_e nx;
    case (kind)
      SNP_INV:  nx = ST_I;
      SNP_DATA: nx = (cur == ST_I) ? ST_I : ST_S;
      default:  nx = cur;
    endcase
    return nx;
  endfunction

  // response code for a snoop given the state found
  function automatic logic [1:0] snoop_code(mesi_e cur, logic [1:0] kind);
    logic [1:0] c;
    if (cur == ST_I)      c = RSP_NONE;
    else if (cur == ST_M) c = RSP_DATA;
    else begin
      case (kind)
        SNP_INV:  c = RSP_NONE;
        SNP_DATA: c = RSP_SHARED;
        default:  c = RSP_KEEP;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/dcsr_tag_state.sv
module dcsr_tag_state
  import dcsr_pkg::*;
#(
  parameter int SETS = 16,
  parameter int TAGW = 22,
  localparam int IDXW = $clog2(SETS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IDXW-1:0] lk_idx,
  input  logic [TAGW-1:0] lk_tag,
  output logic            lk_hit,
  output mesi_e           lk_state,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic            wr_tag_en,
  input  logic [TAGW-1:0] wr_tag,
  input  mesi_e           wr_state
);

  mesi_e           st_q  [SETS];
  logic [TAGW-1:0] tag_q [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SETS; i++) st_q[i] <= ST_I;
    end else if (wr_en) begin
      st_q[wr_idx] <= wr_state;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_tag_en) tag_q[wr_idx] <= wr_tag;
  end

  always_comb begin
    lk_hit   = (st_q[lk_idx] != ST_I) && (tag_q[lk_idx] == lk_tag);
    lk_state = lk_hit ? st_q[lk_idx] : ST_I;
  end

endmodule

// File: rtl/dcsr_line_store.sv
module dcsr_line_store #(
  parameter int SETS   = 16,
  parameter int BEATS  = 2,
  parameter int BEAT_W = 256,
  localparam int IDXW  = $clog2(SETS),
  localparam int BCW   = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int LINE_W = BEATS * BEAT_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDXW-1:0]   wr_idx,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              rd_en,
  input  logic [IDXW-1:0]   rd_idx,
  input  logic [BCW-1:0]    rd_beat,
  output logic [BEAT_W-1:0] rd_data
);

  logic [BEAT_W-1:0] bank_rd [BEATS];
  logic [BCW-1:0]    beat_q;

  // one RAM per beat lane, each with a registered read port
  for (genvar b = 0; b < BEATS; b++) begin : g_bank
    logic [BEAT_W-1:0] mem [SETS];
    logic [BEAT_W-1:0] q;
    always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= wr_line[b*BEAT_W +: BEAT_W];
      if (rd_en) q <= mem[rd_idx];
    end
    assign bank_rd[b] = q;
  end

  always_ff @(posedge clk) begin
    if (rd_en) beat_q <= rd_beat;
  end

  assign rd_data = bank_rd[beat_q];

endmodule

// File: rtl/dcsr_rsp_order.sv
module dcsr_rsp_order #(
  parameter int AW    = 32,
  parameter int OFS   = 6,
  parameter int HCW   = 4,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int EW   = AW + HCW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [AW-1:0]     in_addr,
  input  logic [HCW-1:0]    in_code,
  input  logic              pa_valid,
  input  logic [AW-OFS-1:0] pa_line,
  input  logic              pb_valid,
  input  logic [AW-OFS-1:0] pb_line,
  output logic              out_valid,
  output logic [AW-1:0]     out_addr,
  output logic [HCW-1:0]    out_code
);

  logic [EW-1:0]   q_mem [DEPTH];
  logic [PW-1:0]   wr_ptr, rd_ptr;
  logic [CNTW-1:0] cnt;
  logic [EW-1:0]   head;
  logic [AW-OFS-1:0] head_line;
  logic            blocked, pop;

  assign head      = q_mem[rd_ptr];
  assign head_line = head[EW-1 -: (AW-OFS)];
  assign blocked   = (pa_valid && pa_line == head_line) ||
                     (pb_valid && pb_line == head_line);
  assign pop       = (cnt != '0) && !blocked;

  always_ff @(posedge clk) begin
    if (in_valid) q_mem[wr_ptr] <= {in_addr, in_code};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_code  <= '0;
    end else begin
      if (in_valid) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)      rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      cnt       <= cnt + CNTW'(in_valid) - CNTW'(pop);
      out_valid <= pop;
      if (pop) begin
        out_addr <= head[EW-1 -: AW];
        out_code <= head[HCW-1:0];
      end
    end
  end

  // R9: the host channel is never throttled, so the queue must not overflow
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cnt == CNTW'(DEPTH)) |-> pop);

  // R9: a released response never leaves while its line is being snooped
  p_hold_behind_snoop_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !($past(pa_valid) && $past(pa_line) == out_addr[AW-1:OFS]));

endmodule

// File: rtl/dc_snoop_responder.sv
module dc_snoop_responder
  import dcsr_pkg::*;
#(
  parameter int AW      = 32,
  parameter int SETS    = 16,
  parameter int LINE_B  = 64,
  parameter int BEAT_W  = 256,
  parameter int HCW     = 4,
  parameter int HQ_DEPTH = 4,
  localparam int OFS    = $clog2(LINE_B),
  localparam int IDXW   = $clog2(SETS),
  localparam int LW     = AW - OFS,
  localparam int TAGW   = LW - IDXW,
  localparam int LINE_W = LINE_B * 8,
  localparam int BEATS  = LINE_W / BEAT_W,
  localparam int BCW    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snp_valid,
  output logic              snp_ready,
  input  logic [AW-1:0]     snp_addr,
  input  logic [1:0]        snp_type,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [AW-1:0]     rsp_addr,
  output logic              dat_valid,
  output logic [BEAT_W-1:0] dat_beat,
  input  logic              hin_valid,
  input  logic [AW-1:0]     hin_addr,
  input  logic [HCW-1:0]    hin_code,
  output logic              hout_valid,
  output logic [AW-1:0]     hout_addr,
  output logic [HCW-1:0]    hout_code,
  input  logic              loc_valid,
  output logic              loc_ready,
  input  logic              loc_op,
  input  logic [LW-1:0]     loc_line,
  input  logic [1:0]        loc_fill_st,
  input  logic [LINE_W-1:0] loc_data,
  output logic              loc_err
);

  logic            busy;
  logic [BCW-1:0]  beat_cnt;
  logic [IDXW-1:0] set_q;
  logic [LW-1:0]   line_q;

  logic            snp_acc, loc_acc;
  logic [LW-1:0]   lk_line;
  logic            lk_hit;
  mesi_e           lk_state;
  logic            wr_en, wr_tag_en, store_wr;
  mesi_e           wr_state;
  logic            own_ok;
  logic [1:0]      code_now;

  assign snp_ready = !busy;
  assign loc_ready = !busy && !snp_valid;
  assign snp_acc   = snp_valid && !busy;
  assign loc_acc   = loc_valid && loc_ready;

  assign lk_line   = snp_valid ? snp_addr[AW-1:OFS] : loc_line;
  assign own_ok    = lk_hit && (lk_state == ST_E || lk_state == ST_M);
  assign code_now  = snoop_code(lk_state, snp_type);

  always_comb begin
    wr_en     = 1'b0;
    wr_tag_en = 1'b0;
    wr_state  = lk_state;
    store_wr  = 1'b0;
    if (snp_acc) begin
      wr_en    = lk_hit;
      wr_state = snoop_next(lk_state, snp_type);
    end else if (loc_acc) begin
      if (!loc_op) begin
        wr_en     = 1'b1;
        wr_tag_en = 1'b1;
        wr_state  = mesi_e'(loc_fill_st);
        store_wr  = 1'b1;
      end else if (own_ok) begin
        wr_en    = 1'b1;
        wr_state = ST_M;
        store_wr = 1'b1;
      end
    end
  end

  dcsr_tag_state #(.SETS(SETS), .TAGW(TAGW)) u_tags (
    .clk       (clk),
    .rst       (rst),
    .lk_idx    (lk_line[IDXW-1:0]),
    .lk_tag    (lk_line[LW-1:IDXW]),
    .lk_hit    (lk_hit),
    .lk_state  (lk_state),
    .wr_en     (wr_en),
    .wr_idx    (lk_line[IDXW-1:0]),
    .wr_tag_en (wr_tag_en),
    .wr_tag    (lk_line[LW-1:IDXW]),
    .wr_state  (wr_state)
  );

  dcsr_line_store #(.SETS(SETS), .BEATS(BEATS), .BEAT_W(BEAT_W)) u_store (
    .clk     (clk),
    .wr_en   (store_wr),
    .wr_idx  (lk_line[IDXW-1:0]),
    .wr_line (loc_data),
    .rd_en   (busy),
    .rd_idx  (set_q),
    .rd_beat (beat_cnt),
    .rd_data (dat_beat)
  );

  dcsr_rsp_order #(.AW(AW), .OFS(OFS), .HCW(HCW), .DEPTH(HQ_DEPTH)) u_order (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (hin_valid),
    .in_addr   (hin_addr),
    .in_code   (hin_code),
    .pa_valid  (busy),
    .pa_line   (line_q),
    .pb_valid  (snp_valid),
    .pb_line   (snp_addr[AW-1:OFS]),
    .out_valid (hout_valid),
    .out_addr  (hout_addr),
    .out_code  (hout_code)
  );

  // snoop response and data-beat sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      beat_cnt  <= '0;
      set_q     <= '0;
      line_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_code  <= RSP_NONE;
      rsp_addr  <= '0;
      dat_valid <= 1'b0;
      loc_err   <= 1'b0;
    end else begin
      rsp_valid <= snp_acc;
      dat_valid <= busy;
      loc_err   <= loc_acc && loc_op && !own_ok;
      if (snp_acc) begin
        rsp_code <= code_now;
        rsp_addr <= snp_addr;
        if (code_now == RSP_DATA) begin
          busy     <= 1'b1;
          beat_cnt <= '0;
          set_q    <= snp_addr[OFS +: IDXW];
          line_q   <= snp_addr[AW-1:OFS];
        end
      end else if (busy) begin
        beat_cnt <= beat_cnt + 1'b1;
        if (beat_cnt == BCW'(BEATS - 1)) busy <= 1'b0;
      end
    end
  end

  // R7: a response answers the handshake of the previous cycle
  p_rsp_after_accept_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(snp_valid && snp_ready));

  // R7: the first beat follows a data-carrying response
  p_beat_after_rsp_r7: assert property (@(posedge clk) disable iff (rst)
    (dat_valid && !$past(dat_valid)) |-> $past(rsp_valid && rsp_code == RSP_DATA));

  // R7: the snoop input closes while a dirty line streams out
  p_ready_low_on_data_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code == RSP_DATA) |-> !snp_ready);

  // R8: a write to a Shared line is refused
  p_shared_write_err_r8: assert property (@(posedge clk) disable iff (rst)
    (loc_valid && loc_ready && loc_op && lk_state == ST_S) |=> loc_err);

  // R10: local updates never share a cycle with a waiting snoop
  p_local_yields_r10: assert property (@(posedge clk) disable iff (rst)
    snp_valid |-> !loc_ready);

endmodule

// File: tb/dc_snoop_responder_bench.sv
module dc_snoop_responder_bench;

  localparam int AW = 32;
  localparam int LW = AW - 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic         snp_valid = 0, snp_ready;
  logic [31:0]  snp_addr = 0;
  logic [1:0]   snp_type = 0;
  logic         rsp_valid;
  logic [1:0]   rsp_code;
  logic [31:0]  rsp_addr;
  logic         dat_valid;
  logic [255:0] dat_beat;
  logic         hin_valid = 0;
  logic [31:0]  hin_addr = 0;
  logic [3:0]   hin_code = 0;
  logic         hout_valid;
  logic [31:0]  hout_addr;
  logic [3:0]   hout_code;
  logic         loc_valid = 0, loc_ready, loc_op = 0;
  logic [LW-1:0] loc_line = 0;
  logic [1:0]   loc_fill_st = 0;
  logic [511:0] loc_data = 0;
  logic         loc_err;

  dc_snoop_responder u_dc_snoop_responder (
    .clk(clk), .rst(rst),
    .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_addr(snp_addr), .snp_type(snp_type),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_addr(rsp_addr),
    .dat_valid(dat_valid), .dat_beat(dat_beat),
    .hin_valid(hin_valid), .hin_addr(hin_addr), .hin_code(hin_code),
    .hout_valid(hout_valid), .hout_addr(hout_addr), .hout_code(hout_code),
    .loc_valid(loc_valid), .loc_ready(loc_ready), .loc_op(loc_op), .loc_line(loc_line),
    .loc_fill_st(loc_fill_st), .loc_data(loc_data), .loc_err(loc_err)
  );

  int vecs = 0;
  int bad  = 0;
  int cyc  = 0;
  bit done = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      bad++;
      $display("FAIL watchdog: run hung at cycle %0d (expected completion)", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [511:0] pat(input logic [7:0] seed);
    logic [511:0] p;
    for (int i = 0; i < 16; i++)
      p[i*32 +: 32] = {seed, 8'(i), ~seed, seed ^ 8'(i * 7)};
    return p;
  endfunction

  // op: 0 fill, 1 write, 2 snoop ; arg: fill state or snoop kind ; exp: err or code
  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  arg;
    logic [1:0]  exp;
    logic [7:0]  seed;
    logic [31:0] addr;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{2'd2, 2'd0, 2'd0, 8'h00, 32'h0000_1040},  // R1 reset lines invalid
    '{2'd0, 2'd3, 2'd0, 8'h11, 32'h0000_1040},  // R2 fill M
    '{2'd2, 2'd2, 2'd3, 8'h11, 32'h0000_1040},  // R5 current on M
    '{2'd2, 2'd2, 2'd3, 8'h11, 32'h0000_1040},  // R5 still M
    '{2'd2, 2'd1, 2'd0, 8'h00, 32'h0000_2040},  // R6 tag mismatch same set
    '{2'd2, 2'd1, 2'd3, 8'h11, 32'h0000_1040},  // R4 M -> S with data
    '{2'd2, 2'd2, 2'd2, 8'h00, 32'h0000_1040},  // R5 S unchanged
    '{2'd1, 2'd0, 2'd1, 8'h22, 32'h0000_1040},  // R8 write to S refused
    '{2'd2, 2'd2, 2'd2, 8'h00, 32'h0000_1040},  // R8 still S after refusal
    '{2'd2, 2'd0, 2'd0, 8'h00, 32'h0000_1040},  // R3 S -> I
    '{2'd2, 2'd2, 2'd0, 8'h00, 32'h0000_1040},  // R6 invalid line
    '{2'd0, 2'd2, 2'd0, 8'h33, 32'h0000_0080},  // R2 fill E
    '{2'd2, 2'd2, 2'd2, 8'h00, 32'h0000_0080},  // R5 E unchanged
    '{2'd2, 2'd3, 2'd2, 8'h00, 32'h0000_0080},  // R5 kind 11 as current
    '{2'd1, 2'd0, 2'd0, 8'h44, 32'h0000_0080},  // R8 write E -> M
    '{2'd2, 2'd2, 2'd3, 8'h44, 32'h0000_0080},  // R8 new data returned
    '{2'd2, 2'd0, 2'd3, 8'h44, 32'h0000_0080},  // R3 M -> I with data
    '{2'd2, 2'd1, 2'd0, 8'h00, 32'h0000_0080},  // R3 line now invalid
    '{2'd1, 2'd0, 2'd1, 8'h55, 32'h0000_00C0},  // R8 write miss refused
    '{2'd2, 2'd2, 2'd0, 8'h00, 32'h0000_00C0},  // R8 miss left invalid
    '{2'd0, 2'd1, 2'd0, 8'h66, 32'h0000_03C0},  // R2 fill S set 15
    '{2'd2, 2'd1, 2'd1, 8'h00, 32'h0000_03C0},  // R4 S data snoop
    '{2'd2, 2'd0, 2'd0, 8'h00, 32'h0000_03C0},  // R3 S inval
    '{2'd0, 2'd2, 2'd0, 8'h77, 32'h0000_FFC0},  // R2 fill E set 15 other tag
    '{2'd2, 2'd1, 2'd1, 8'h00, 32'h0000_FFC0},  // R4 E -> S
    '{2'd2, 2'd2, 2'd2, 8'h00, 32'h0000_FFC0},  // R4 now S
    '{2'd0, 2'd3, 2'd0, 8'h88, 32'h0000_0100},  // R2 fill M set 4
    '{2'd1, 2'd0, 2'd0, 8'h99, 32'h0000_0100},  // R8 write M stays M
    '{2'd2, 2'd0, 2'd3, 8'h99, 32'h0000_0100},  // R3 M -> I new data
    '{2'd2, 2'd0, 2'd0, 8'h00, 32'h0000_0100}   // R3 invalid after
  };

  task automatic do_snoop(input logic [31:0] a, input logic [1:0] k,
                          input logic [1:0] exp, input logic [7:0] seed);
    logic [511:0] p;
    p = pat(seed);
    @(negedge clk);
    snp_valid = 1; snp_addr = a; snp_type = k;
    while (!snp_ready) @(negedge clk);
    @(negedge clk);
    snp_valid = 0;
    chk(rsp_valid == 1'b1, "R7", "response pulse", 512'(rsp_valid), 512'd1);
    chk(rsp_code == exp, "R3/R4/R5/R6", "response code", 512'(rsp_code), 512'(exp));
    chk(rsp_addr == a, "R7", "response address", 512'(rsp_addr), 512'(a));
    chk(snp_ready == (exp != 2'd3), "R7", "snoop ready after response",
        512'(snp_ready), 512'(exp != 2'd3));
    if (exp == 2'd3) begin
      @(negedge clk);
      chk(dat_valid && dat_beat == p[255:0], "R7", "beat low half",
          512'(dat_beat), 512'(p[255:0]));
      @(negedge clk);
      chk(dat_valid && dat_beat == p[511:256], "R7", "beat high half",
          512'(dat_beat), 512'(p[511:256]));
    end
    @(negedge clk);
    chk(!dat_valid && !rsp_valid, "R6", "outputs quiet after snoop",
        512'({dat_valid, rsp_valid}), 512'd0);
  endtask

  task automatic do_local(input logic op, input logic [31:0] a, input logic [1:0] st,
                          input logic [7:0] seed, input logic exp_err);
    @(negedge clk);
    loc_valid = 1; loc_op = op; loc_line = a[31:6]; loc_fill_st = st; loc_data = pat(seed);
    while (!loc_ready) @(negedge clk);
    @(negedge clk);
    loc_valid = 0;
    if (op) chk(loc_err == exp_err, "R8", "write error flag", 512'(loc_err), 512'(exp_err));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(snp_ready && loc_ready, "R1", "ready after reset", 512'({snp_ready, loc_ready}), 512'd3);
    chk(!rsp_valid && !dat_valid && !hout_valid && !loc_err, "R1", "outputs idle after reset",
        512'({rsp_valid, dat_valid, hout_valid, loc_err}), 512'd0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd0: do_local(1'b0, VEC[i].addr, VEC[i].arg, VEC[i].seed, 1'b0);
        2'd1: do_local(1'b1, VEC[i].addr, 2'd0, VEC[i].seed, VEC[i].exp[0]);
        default: do_snoop(VEC[i].addr, VEC[i].arg, VEC[i].exp, VEC[i].seed);
      endcase
    end

    // R10: a waiting snoop closes the local port
    @(negedge clk);
    snp_valid = 1; snp_addr = 32'h0000_0200; snp_type = 2'd2;
    loc_valid = 1; loc_op = 1'b0; loc_line = 26'h8; loc_fill_st = 2'd3;
    #1;
    chk(loc_ready == 1'b0, "R10", "local blocked by snoop", 512'(loc_ready), 512'd0);
    @(negedge clk);
    snp_valid = 0; loc_valid = 0;
    chk(rsp_valid && rsp_code == 2'd0, "R10", "snoop served first", 512'(rsp_code), 512'd0);
    @(negedge clk);

    // R9: host response to a line under a dirty snoop is held
    do_local(1'b0, 32'h0000_0140, 2'd3, 8'hAB, 1'b0);
    @(negedge clk);
    snp_valid = 1; snp_addr = 32'h0000_0140; snp_type = 2'd0;
    hin_valid = 1; hin_addr = 32'h0000_0148; hin_code = 4'hA;
    @(negedge clk);
    snp_valid = 0; hin_valid = 0;
    chk(rsp_valid && rsp_code == 2'd3, "R9", "dirty snoop answered", 512'(rsp_code), 512'd3);
    chk(!hout_valid, "R9", "held during response", 512'(hout_valid), 512'd0);
    @(negedge clk);
    chk(!hout_valid && dat_valid, "R9", "held during beat 0", 512'(hout_valid), 512'd0);
    @(negedge clk);
    chk(!hout_valid && dat_valid, "R9", "held during beat 1", 512'(hout_valid), 512'd0);
    @(negedge clk);
    chk(hout_valid && hout_addr == 32'h0000_0148 && hout_code == 4'hA, "R9",
        "released after last beat", 512'({hout_valid, hout_addr}), 512'({1'b1, 32'h0000_0148}));

    // R9: unrelated line passes in two cycles
    @(negedge clk);
    hin_valid = 1; hin_addr = 32'h0000_0500; hin_code = 4'h3;
    @(negedge clk);
    hin_valid = 0;
    chk(!hout_valid, "R9", "not out after one cycle", 512'(hout_valid), 512'd0);
    @(negedge clk);
    chk(hout_valid && hout_addr == 32'h0000_0500 && hout_code == 4'h3, "R9",
        "pass-through after two cycles", 512'(hout_addr), 512'h500);
    @(negedge clk);
    chk(!hout_valid, "R9", "single output pulse", 512'(hout_valid), 512'd0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule